// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge Chain

This block collects interrupt events from two serial channels, each channel offering five event types (receiver ready, transmitter ready, receiver condition, receive/transmit status, and port-change or counter/timer). Every event latches a pending bit. The bit stays set until the register logic around the block sends a clear strobe, for example when the receive FIFO is read, the transmit FIFO is written, or a status register is written. A per-source enable bit decides whether a pending source drives the active-low request line. The raw pending bits are always visible on a status port, so software can poll without running an acknowledge cycle.

When the host runs an acknowledge cycle and at least one enabled source is pending, the block captures a vector at the start of the cycle and drives it on the data bus with the transfer acknowledge. The vector is the programmed vector register, or, in status-merged mode, that register with its low bits replaced by the identity of the highest-priority enabled source. The captured vector and the acknowledge stay fixed until the cycle ends. If nothing enabled is pending, the block keeps its acknowledge inactive and passes the acknowledge on through its chain output to devices of lower priority. The priority order among the ten internal sources is programmable.

Top module: `vic_chain`

## Requirements
- R1: After synchronous reset, irq_n, dtack_n and chain_n are 1, data_oe is 0, data_o is 0, all pending bits are 0, all enable bits are 0, and the vector and control registers are 0.
- R2: A 1 on src_set[i] at a clock edge makes pend_o[i] read 1 from the next cycle, whatever the enable bit of that source. Source index i is ch*5+type, with channel 0 or 1 and type 0 to 4.
- R3: A 1 on src_clr[i] clears pending bit i at the next edge. If src_set[i] and src_clr[i] are both 1 in the same cycle, the bit ends up set.
- R4: irq_n is a register. It reads 0 in the cycle after any pending bit whose enable bit is 1, and 1 in the cycle after no such bit exists. A source that is pending but disabled does not pull irq_n low.
- R5: When iack_n is low and the acknowledge logic is idle, and an enabled source is pending at that edge, dtack_n goes to 0 and data_oe to 1 in the next cycle with data_o holding the vector. The three outputs keep those values until iack_n returns high. At the next edge they go back to 1, 0 and 0.
- R6: With control bit 0 set, data_o equals the vector register with bits [3:0] replaced by {channel, type[2:0]} of the winning source. With control bit 0 clear, data_o equals the vector register unchanged.
- R7: The winner is the first enabled pending source in priority order. With control bit 1 clear, all types of the first channel come first, then all types of the second channel, lower type first. With control bit 1 set, the order interleaves the channels by type: type 0 of the first channel, type 0 of the second, type 1 of the first, and so on. Control bit 2 clear makes channel 0 the first channel, and set makes channel 1 the first.
- R8: If no enabled source is pending when the acknowledge cycle starts, chain_n goes to 0 in the next cycle and stays 0 until iack_n returns high, while dtack_n stays 1 and data_oe stays 0. dtack_n and chain_n are never both 0.
- R9: Changes to pending bits, enable bits or the vector during an acknowledge cycle do not change data_o, dtack_n or chain_n until that cycle ends.
- R10: A write with wr_en high updates one register, chosen by wr_addr. Address 0 is the vector (all bits), address 1 the channel 0 enables (wr_data[4:0], bit = type), address 2 the channel 1 enables (wr_data[4:0]), and address 3 the control (wr_data[2:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| src_set | input | 10 | Event pulses, one per source |
| src_clr | input | 10 | Clear strobes from register accesses, one per source |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| chain_n | output | 1 | Acknowledge passed to lower-priority devices, active low |
| data_o | output | 8 | Vector placed on the data bus |
| data_oe | output | 1 | Data bus drive enable |
| pend_o | output | 10 | Raw pending bits for status polling |

## Verification
Two pairs of functions can fall in the same cycle. A source event can coincide with its own clear strobe, and a change to a pending or enable bit can coincide with the start of an acknowledge cycle or arrive in the middle of one. The stimulus pulses src_set and src_clr for the same source in the same cycle. It also sets and clears sources and rewrites the vector while iack_n is held low. A reference model steps alongside the design, with set taking precedence over clear and the vector frozen at the start of the cycle. Every output is compared with that model on every cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NCH = 2;

  localparam logic [1:0] ADDR_VEC    = 2'd0;
  localparam logic [1:0] ADDR_MASK_0 = 2'd1;
  localparam logic [1:0] ADDR_MASK_1 = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;

  localparam int CTRL_MODIFY = 0;
  localparam int CTRL_INTLV  = 1;
  localparam int CTRL_BFIRST = 2;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_SERVE = 2'd1,
    ACK_PASS  = 2'd2
  } ack_st_e;
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int NTYPE = 5,
  localparam int NSRC = vic_pkg::NCH * NTYPE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      set_i,
  input  logic [NSRC-1:0]      clr_i,
  input  logic [vic_pkg::NCH-1:0] mask_we,
  input  logic [NTYPE-1:0]     mask_wd,
  output logic [NSRC-1:0]      pend_o,
  output logic [NSRC-1:0]      mask_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  for (genvar ch = 0; ch < vic_pkg::NCH; ch++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)               mask_q[ch*NTYPE +: NTYPE] <= '0;
      else if (mask_we[ch])  mask_q[ch*NTYPE +: NTYPE] <= mask_wd;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  // R3
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NTYPE = 5,
  localparam int NSRC = vic_pkg::NCH * NTYPE,
  localparam int TW   = (NTYPE > 1) ? $clog2(NTYPE) : 1
) (
  input  logic [NSRC-1:0] req_i,
  input  logic            intlv_i,
  input  logic            bfirst_i,
  output logic            any_o,
  output logic            ch_o,
  output logic [TW-1:0]   type_o
);
  always_comb begin
    any_o  = 1'b0;
    ch_o   = 1'b0;
    type_o = '0;
    // walk ranks from lowest to highest priority so the best one is kept
    for (int r = NSRC - 1; r >= 0; r--) begin
      int c;
      int t;
      if (intlv_i) begin
        c = r % vic_pkg::NCH;
        t = r / vic_pkg::NCH;
      end else begin
        c = r / NTYPE;
        t = r % NTYPE;
      end
      if (bfirst_i) c = 1 - c;
      if (req_i[c*NTYPE + t]) begin
        any_o  = 1'b1;
        ch_o   = (c != 0);
        type_o = TW'(t);
      end
    end
  end
endmodule

// File: rtl/vic_ack.sv
module vic_ack #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iack_n,
  input  logic          any_i,
  input  logic [DW-1:0] vec_i,
  output logic          dtack_n,
  output logic          chain_n,
  output logic          data_oe,
  output logic [DW-1:0] data_o
);
  import vic_pkg::*;

  ack_st_e       st_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ACK_IDLE;
      data_q <= '0;
    end else begin
      case (st_q)
        ACK_IDLE: begin
          if (!iack_n) begin
            if (any_i) begin
              st_q   <= ACK_SERVE;
              data_q <= vec_i;
            end else begin
              st_q   <= ACK_PASS;
            end
          end
        end
        default: begin
          if (iack_n) begin
            st_q   <= ACK_IDLE;
            data_q <= '0;
          end
        end
      endcase
    end
  end

  assign dtack_n = (st_q != ACK_SERVE);
  assign chain_n = (st_q != ACK_PASS);
  assign data_oe = (st_q == ACK_SERVE);
  assign data_o  = data_q;

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!dtack_n && !chain_n));

  // R5
  serve_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ACK_IDLE && !iack_n && any_i) |=> (!dtack_n && data_oe));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && $past(!dtack_n) && !$past(iack_n)) |-> $stable(data_o));
endmodule

// File: rtl/vic_chain.sv
module vic_chain #(
  parameter int NTYPE = 5,
  parameter int DW    = 8,
  localparam int NSRC = vic_pkg::NCH * NTYPE,
  localparam int TW   = (NTYPE > 1) ? $clog2(NTYPE) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic            iack_n,
  output logic            irq_n,
  output logic            dtack_n,
  output logic            chain_n,
  output logic [DW-1:0]   data_o,
  output logic            data_oe,
  output logic [NSRC-1:0] pend_o
);
  import vic_pkg::*;

  logic [DW-1:0]   vec_q;
  logic [2:0]      ctrl_q;
  logic            irq_n_q;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] mask;
  logic [NCH-1:0]  mask_we;
  logic            win_any;
  logic            win_ch;
  logic [TW-1:0]   win_type;
  logic [DW-1:0]   vec_cmp;

  assign mask_we[0] = wr_en && (wr_addr == ADDR_MASK_0);
  assign mask_we[1] = wr_en && (wr_addr == ADDR_MASK_1);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= '0;
      ctrl_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (wr_en && wr_addr == ADDR_VEC)  vec_q  <= wr_data;
      if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data[2:0];
      irq_n_q <= ~|(pend & mask);
    end
  end

  vic_pend #(.NTYPE(NTYPE)) i_pend (
    .clk     (clk),
    .rst     (rst),
    .set_i   (src_set),
    .clr_i   (src_clr),
    .mask_we (mask_we),
    .mask_wd (wr_data[NTYPE-1:0]),
    .pend_o  (pend),
    .mask_o  (mask)
  );

  vic_arb #(.NTYPE(NTYPE)) i_arb (
    .req_i    (pend & mask),
    .intlv_i  (ctrl_q[CTRL_INTLV]),
    .bfirst_i (ctrl_q[CTRL_BFIRST]),
    .any_o    (win_any),
    .ch_o     (win_ch),
    .type_o   (win_type)
  );

  always_comb begin
    vec_cmp = vec_q;
    if (ctrl_q[CTRL_MODIFY]) vec_cmp[TW:0] = {win_ch, win_type};
  end

  vic_ack #(.DW(DW)) i_ack (
    .clk     (clk),
    .rst     (rst),
    .iack_n  (iack_n),
    .any_i   (win_any),
    .vec_i   (vec_cmp),
    .dtack_n (dtack_n),
    .chain_n (chain_n),
    .data_oe (data_oe),
    .data_o  (data_o)
  );

  assign irq_n  = irq_n_q;
  assign pend_o = pend;

  // R4
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend & mask)) |=> !irq_n);

  // R4
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & mask)) |=> irq_n);
endmodule

// File: tb/test_vic_chain.sv
module test_vic_chain;
  localparam int NT = 5;
  localparam int NS = 10;
  localparam int DW = 8;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_en = 0;
  logic [1:0]    wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [NS-1:0] src_set = 0;
  logic [NS-1:0] src_clr = 0;
  logic          iack_n = 1;
  logic          irq_n, dtack_n, chain_n, data_oe;
  logic [DW-1:0] data_o;
  logic [NS-1:0] pend_o;

  vic_chain i_vic_chain (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_set(src_set), .src_clr(src_clr), .iack_n(iack_n),
    .irq_n(irq_n), .dtack_n(dtack_n), .chain_n(chain_n),
    .data_o(data_o), .data_oe(data_oe), .pend_o(pend_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "R1";

  // reference model state
  logic [NS-1:0] m_pend, m_mask;
  logic [DW-1:0] m_vec, m_data;
  logic [2:0]    m_ctrl;
  logic          m_irq_n;
  int            m_st; // 0 idle, 1 serving, 2 passing

  function automatic void pick(input logic [NS-1:0] req, input logic [2:0] ctrl,
                               output bit any, output int ch, output int tp);
    int oc[$];
    int ot[$];
    int first = ctrl[2] ? 1 : 0;
    if (ctrl[1]) begin
      for (int t = 0; t < NT; t++) begin
        oc.push_back(first);     ot.push_back(t);
        oc.push_back(1 - first); ot.push_back(t);
      end
    end else begin
      for (int k = 0; k < 2; k++)
        for (int t = 0; t < NT; t++) begin
          oc.push_back(k == 0 ? first : 1 - first); ot.push_back(t);
        end
    end
    any = 0; ch = 0; tp = 0;
    foreach (oc[k]) if (!any && req[oc[k]*NT + ot[k]]) begin
      any = 1; ch = oc[k]; tp = ot[k];
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_pend = 0; m_mask = 0; m_vec = 0; m_data = 0; m_ctrl = 0;
      m_irq_n = 1; m_st = 0;
    end else begin
      bit any; int ch; int tp;
      logic [DW-1:0] v;
      pick(m_pend & m_mask, m_ctrl, any, ch, tp);
      v = m_vec;
      if (m_ctrl[0]) v[3:0] = {ch[0], tp[2:0]};
      if (m_st == 0) begin
        if (!iack_n) begin
          if (any) begin m_st = 1; m_data = v; end
          else m_st = 2;
        end
      end else if (iack_n) begin
        m_st = 0; m_data = 0;
      end
      m_irq_n = !(|(m_pend & m_mask));
      m_pend = (m_pend & ~src_clr) | src_set;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_vec = wr_data;
          2'd1: m_mask[4:0] = wr_data[4:0];
          2'd2: m_mask[9:5] = wr_data[4:0];
          default: m_ctrl = wr_data[2:0];
        endcase
      end
    end
  end

  task automatic chk(string sig, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", phase, sig, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (cyc > 0) begin
    chk("irq_n",   32'(irq_n),   32'(m_irq_n));
    chk("dtack_n", 32'(dtack_n), 32'(m_st != 1));
    chk("chain_n", 32'(chain_n), 32'(m_st != 2));
    chk("data_oe", 32'(data_oe), 32'(m_st == 1));
    chk("data_o",  32'(data_o),  32'(m_data));
    chk("pend_o",  32'(pend_o),  32'(m_pend));
  end

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #2 wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2 wr_en = 0;
  endtask

  task automatic sc(input logic [NS-1:0] s, input logic [NS-1:0] c);
    @(posedge clk); #2 src_set = s; src_clr = c;
    @(posedge clk); #2 src_set = 0; src_clr = 0;
  endtask

  task automatic ack(input int hold);
    @(posedge clk); #2 iack_n = 0;
    repeat (hold) @(posedge clk);
    #2 iack_n = 1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    repeat (3) @(posedge clk);
    // R2 / R4: pending while disabled keeps irq_n high
    phase = "R2"; sc(10'b00000_00100, 0);
    phase = "R4"; repeat (2) @(posedge clk);
    // R10: register map
    phase = "R10";
    wr(2'd0, 8'hA0); wr(2'd1, 8'h1F); wr(2'd2, 8'h1F); wr(2'd3, 8'h00);
    phase = "R4"; repeat (2) @(posedge clk);
    // R3: clear, then set and clear together
    phase = "R3"; sc(0, 10'b00000_00100);
    sc(10'b00010_00000, 10'b00010_00000);
    repeat (2) @(posedge clk);
    // R5: plain vector
    phase = "R5"; ack(4);
    // R6: status-merged vector
    phase = "R6"; wr(2'd3, 8'h01); ack(3);
    // R7: priority orders with A type3 and B type1 pending
    phase = "R7";
    sc(10'b00010_01000, 10'b00010_00000);
    sc(10'b00010_00000, 0);
    wr(2'd3, 8'h01); ack(2);
    wr(2'd3, 8'h05); ack(2);
    wr(2'd3, 8'h03); ack(2);
    wr(2'd3, 8'h07); ack(2);
    sc(10'b00000_00001, 0);
    wr(2'd3, 8'h07); ack(2);
    wr(2'd2, 8'h00); ack(2);
    // R9: changes during a served cycle
    phase = "R9";
    @(posedge clk); #2 iack_n = 0;
    @(posedge clk); #2 src_set = 10'b11111_00000; src_clr = 10'b00000_00001;
    @(posedge clk); #2 src_set = 0; src_clr = 0; wr_en = 1; wr_addr = 0; wr_data = 8'h55;
    @(posedge clk); #2 wr_en = 0;
    repeat (2) @(posedge clk); #2 iack_n = 1;
    repeat (2) @(posedge clk);
    // R8: nothing enabled pending -> pass the acknowledge on
    phase = "R8";
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    ack(4);
    sc(0, 10'h3FF); ack(2);
    // R1: reset mid-operation
    phase = "R1";
    sc(10'h3FF, 0);
    @(posedge clk); #2 rst = 1;
    repeat (2) @(posedge clk); #2 rst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule